// File: doc/BRIEF.md
# Protected Status Register for a Serial Flash Controller

This block keeps the eight-bit status byte of a serial flash device and decides when that byte may change. A serial front end decodes the instruction stream. It hands this block three things: a strobe when an opcode byte is complete, a strobe for each following data byte, and a pulse when chip select rises to close the frame. Commands take effect on that closing pulse. They can set or clear the write-enable latch, arm a status write, or perform a status write. The write sequencer supplies the busy level and the auto-increment flag events, and it clears the latch when a program or erase finishes.

A status write works in two steps. The arming opcode must be the instruction immediately before the write. Any other completed instruction cancels the arming, and that includes a status read. A write-protect pin, active low, together with the lock bit decides whether the write is accepted. That decision is made in the cycle that closes the write frame. The block also decodes the two protect bits into the protected top region of the array. It flags whether a probe address falls inside that region.

Top module: `srx_status_reg`

## Requirements
- R1: After reset the status byte reads 0x0C (protect bits both 1, every other bit 0). The whole array is protected: `range_any`=1 and `range_base`=0.
- R2: The enable opcode 0x06 sets status bit 1 when its frame closes. A frame that closes without any opcode changes nothing.
- R3: The disable opcode 0x04 clears status bit 1 and status bit 6 when its frame closes. This takes priority over a coincident `aai_set`.
- R4: A `wel_drop` pulse clears status bit 1. It wins over a coincident enable.
- R5: Status bit 0 shows `busy_in` one clock later. Status bit 6 is set by `aai_set` and cleared by `aai_clr`.
- R6: The write opcode 0x01 acts only when the previous completed instruction was 0x50. Any other completed instruction, such as the read opcode 0x05, cancels the arming. Only data bits 7, 3 and 2 are taken, into lock, BP1 and BP0.
- R7: A write frame that closes before its data byte arrives changes nothing.
- R8: With `guard_n` low and lock at 1, a write is refused and lock, BP1 and BP0 keep their values.
- R9: With `guard_n` low and lock at 0, one write sets lock and changes BP1 and BP0 together.
- R10: With `guard_n` high, a write may clear lock and change BP1 and BP0 whatever lock holds.
- R11: BP1,BP0 = 00 means nothing is protected. 01 protects from 3/4 of the address space to the top (0xC000 for 16 bits), 10 from half, and 11 from 0. `probe_locked` is 1 exactly when `probe_addr` is at or above the base and a range exists.
- R12: Status bits 5 and 4 always read 0.
- R13: `guard_n` is sampled in the cycle that closes the write frame, not while the data byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Opcode byte complete |
| op_code | input | 8 | Opcode value |
| wdata_valid | input | 1 | Data byte complete |
| wdata | input | 8 | Data byte value |
| frame_end | input | 1 | Chip select rose, frame closed |
| guard_n | input | 1 | Write-protect pin, active low |
| busy_in | input | 1 | Sequencer busy level |
| aai_set | input | 1 | Sequencer enters auto-increment mode |
| aai_clr | input | 1 | Sequencer leaves auto-increment mode |
| wel_drop | input | 1 | Sequencer finished a write, clear latch |
| probe_addr | input | AW | Address to test against the range |
| status_byte | output | 8 | Status byte for reads |
| range_any | output | 1 | Some region is protected |
| range_base | output | AW | Lowest protected address |
| probe_locked | output | 1 | Probe address is protected |

## Verification
Every register field shows up on `status_byte` exactly one clock after the cycle that carries its cause. That cause is the `frame_end` pulse for commands, the level of `busy_in`, or an `aai_set`, `aai_clr` or `wel_drop` pulse. The range outputs and `probe_locked` are combinational from the protect bits, so they settle in that same cycle. The bench drives every pulse for one cycle starting at a falling edge and then waits for the next falling edge before it samples. This puts every check half a period after the one register stage.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam logic [7:0] OP_WSR  = 8'h01;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_ARM  = 8'h50;

  typedef struct packed {
    logic       lock;
    logic       aai;
    logic [1:0] rsv;
    logic [1:0] bp;
    logic       wel;
    logic       busy;
  } stat_t;

  // Lowest protected address for a given protect code and address width.
  function automatic logic [31:0] lock_floor(input logic [1:0] bp, input int aw);
    case (bp)
      2'b01:   lock_floor = 32'd3 << (aw - 2);
      2'b10:   lock_floor = 32'd1 << (aw - 1);
      default: lock_floor = 32'd0;
    endcase
  endfunction

  // A status write is refused only when the pin is asserted and the lock is set.
  function automatic logic wsr_allowed(input logic guard_n, input logic lock);
    wsr_allowed = guard_n | ~lock;
  endfunction
endpackage

// File: rtl/srx_frame_track.sv
module srx_frame_track
  import srx_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic           wdata_valid,
  input  logic           dat_lock,
  input  logic [1:0]     dat_bp,
  input  logic           frame_end,
  output logic           ex_wren,
  output logic           ex_wrdi,
  output logic           ex_wsr_try,
  output logic           armed_o,
  output logic           new_lock,
  output logic [1:0]     new_bp
);
  logic           have_op, have_dat, armed;
  logic [OPW-1:0] op_q;
  logic           lock_q;
  logic [1:0]     bp_q;
  logic           ex_any;

  assign ex_any     = frame_end & have_op;
  assign ex_wren    = ex_any & (op_q == OP_WREN);
  assign ex_wrdi    = ex_any & (op_q == OP_WRDI);
  assign ex_wsr_try = ex_any & (op_q == OP_WSR) & have_dat & armed;
  assign armed_o    = armed;
  assign new_lock   = lock_q;
  assign new_bp     = bp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_op  <= 1'b0;
      have_dat <= 1'b0;
      armed    <= 1'b0;
      op_q     <= '0;
      lock_q   <= 1'b0;
      bp_q     <= 2'b00;
    end else if (frame_end) begin
      have_op  <= 1'b0;
      have_dat <= 1'b0;
      if (have_op) armed <= (op_q == OP_ARM);
    end else begin
      if (op_valid && !have_op) begin
        have_op <= 1'b1;
        op_q    <= op_code;
      end
      if (wdata_valid && have_op && !have_dat && op_q == OP_WSR) begin
        have_dat <= 1'b1;
        lock_q   <= dat_lock;
        bp_q     <= dat_bp;
      end
    end
  end
endmodule

// File: rtl/srx_bits.sv
module srx_bits
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy_in,
  input  logic       aai_set,
  input  logic       aai_clr,
  input  logic       wel_drop,
  input  logic       ex_wren,
  input  logic       ex_wrdi,
  input  logic       ex_wsr_try,
  input  logic       guard_n,
  input  logic       new_lock,
  input  logic [1:0] new_bp,
  output stat_t      stat
);
  logic       busy_q, wel_q, aai_q, lock_q;
  logic [1:0] bp_q;
  logic       accept;

  assign accept = ex_wsr_try & wsr_allowed(guard_n, lock_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      aai_q  <= 1'b0;
      lock_q <= 1'b0;
      bp_q   <= 2'b11;
    end else begin
      busy_q <= busy_in;
      if (ex_wrdi || wel_drop) wel_q <= 1'b0;
      else if (ex_wren)        wel_q <= 1'b1;
      if (ex_wrdi || aai_clr)  aai_q <= 1'b0;
      else if (aai_set)        aai_q <= 1'b1;
      if (accept) begin
        lock_q <= new_lock;
        bp_q   <= new_bp;
      end
    end
  end

  always_comb begin
    stat.lock = lock_q;
    stat.aai  = aai_q;
    stat.rsv  = 2'b00;
    stat.bp   = bp_q;
    stat.wel  = wel_q;
    stat.busy = busy_q;
  end
endmodule

// File: rtl/srx_range.sv
module srx_range
  import srx_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [1:0]    bp,
  input  logic [AW-1:0] probe_addr,
  output logic          range_any,
  output logic [AW-1:0] range_base,
  output logic          probe_locked
);
  localparam int FW = 32;
  logic [FW-1:0] floor_w;

  assign floor_w      = lock_floor(bp, AW);
  assign range_base   = floor_w[AW-1:0];
  assign range_any    = (bp != 2'b00);
  assign probe_locked = range_any && (probe_addr >= range_base);
endmodule

// File: rtl/srx_status_reg.sv
module srx_status_reg
  import srx_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [7:0]    op_code,
  input  logic          wdata_valid,
  input  logic [7:0]    wdata,
  input  logic          frame_end,
  input  logic          guard_n,
  input  logic          busy_in,
  input  logic          aai_set,
  input  logic          aai_clr,
  input  logic          wel_drop,
  input  logic [AW-1:0] probe_addr,
  output logic [7:0]    status_byte,
  output logic          range_any,
  output logic [AW-1:0] range_base,
  output logic          probe_locked
);
  logic       ex_wren, ex_wrdi, ex_wsr_try, armed;
  logic       new_lock;
  logic [1:0] new_bp;
  stat_t      stat;
  logic       unused_dat;

  assign unused_dat = ^{wdata[6:4], wdata[1:0]};

  srx_frame_track #(.OPW(8)) u_track (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .wdata_valid(wdata_valid), .dat_lock(wdata[7]), .dat_bp(wdata[3:2]),
    .frame_end(frame_end), .ex_wren(ex_wren), .ex_wrdi(ex_wrdi),
    .ex_wsr_try(ex_wsr_try), .armed_o(armed), .new_lock(new_lock),
    .new_bp(new_bp)
  );

  srx_bits u_bits (
    .clk(clk), .rst_n(rst_n), .busy_in(busy_in), .aai_set(aai_set),
    .aai_clr(aai_clr), .wel_drop(wel_drop), .ex_wren(ex_wren),
    .ex_wrdi(ex_wrdi), .ex_wsr_try(ex_wsr_try), .guard_n(guard_n),
    .new_lock(new_lock), .new_bp(new_bp), .stat(stat)
  );

  srx_range #(.AW(AW)) u_range (
    .bp(stat.bp), .probe_addr(probe_addr), .range_any(range_any),
    .range_base(range_base), .probe_locked(probe_locked)
  );

  assign status_byte = stat;
endmodule

// File: rtl/srx_status_chk.sv
module srx_status_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_in,
  input logic          wel_drop,
  input logic          guard_n,
  input logic [7:0]    status_byte,
  input logic          range_any,
  input logic [AW-1:0] range_base,
  input logic [AW-1:0] probe_addr,
  input logic          probe_locked,
  input logic          ex_wren,
  input logic          ex_wrdi,
  input logic          ex_wsr_try,
  input logic          armed
);
  assert_wren_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ex_wren && !wel_drop |=> status_byte[1]);

  assert_wrdi_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ex_wrdi |=> !status_byte[1] && !status_byte[6]);

  assert_drop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wel_drop |=> !status_byte[1]);

  assert_busy_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_in |=> status_byte[0]);

  assert_busy_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_in |=> !status_byte[0]);

  assert_unarmed_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> $stable(status_byte[7]) && $stable(status_byte[3:2]));

  assert_locked_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ex_wsr_try && !guard_n && status_byte[7]
      |=> status_byte[7] && $stable(status_byte[3:2]));

  assert_probe_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    probe_locked |-> range_any && (probe_addr >= range_base));
endmodule

bind srx_status_reg srx_status_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_in(busy_in), .wel_drop(wel_drop),
  .guard_n(guard_n), .status_byte(status_byte), .range_any(range_any),
  .range_base(range_base), .probe_addr(probe_addr),
  .probe_locked(probe_locked), .ex_wren(ex_wren), .ex_wrdi(ex_wrdi),
  .ex_wsr_try(ex_wsr_try), .armed(armed)
);

// File: tb/srx_status_reg_test.sv
module srx_status_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NV = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0, wdata_valid = 1'b0, frame_end = 1'b0;
  logic [7:0]    op_code = 8'h00, wdata = 8'h00;
  logic          guard_n = 1'b1, busy_in = 1'b0;
  logic          aai_set = 1'b0, aai_clr = 1'b0, wel_drop = 1'b0;
  logic [AW-1:0] probe_addr = '0;
  logic [7:0]    status_byte;
  logic          range_any, probe_locked;
  logic [AW-1:0] range_base;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srx_status_reg #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .wdata_valid(wdata_valid), .wdata(wdata), .frame_end(frame_end),
    .guard_n(guard_n), .busy_in(busy_in), .aai_set(aai_set),
    .aai_clr(aai_clr), .wel_drop(wel_drop), .probe_addr(probe_addr),
    .status_byte(status_byte), .range_any(range_any),
    .range_base(range_base), .probe_locked(probe_locked)
  );

  // {opcode, has_data, data, guard_n, expected status}
  localparam logic [25:0] VEC [NV] = '{
    {8'h06, 1'b0, 8'h00, 1'b1, 8'h0E},
    {8'h04, 1'b0, 8'h00, 1'b1, 8'h0C},
    {8'h01, 1'b1, 8'h00, 1'b1, 8'h0C},
    {8'h50, 1'b0, 8'h00, 1'b1, 8'h0C},
    {8'h01, 1'b1, 8'h00, 1'b1, 8'h00},
    {8'h50, 1'b0, 8'h00, 1'b1, 8'h00},
    {8'h05, 1'b0, 8'h00, 1'b1, 8'h00},
    {8'h01, 1'b1, 8'h0C, 1'b1, 8'h00},
    {8'h50, 1'b0, 8'h00, 1'b0, 8'h00},
    {8'h01, 1'b1, 8'hFF, 1'b0, 8'h8C},
    {8'h50, 1'b0, 8'h00, 1'b0, 8'h8C},
    {8'h01, 1'b1, 8'h00, 1'b0, 8'h8C},
    {8'h50, 1'b0, 8'h00, 1'b1, 8'h8C},
    {8'h01, 1'b1, 8'h04, 1'b1, 8'h04},
    {8'h50, 1'b0, 8'h00, 1'b1, 8'h04},
    {8'h01, 1'b0, 8'h00, 1'b1, 8'h04},
    {8'h01, 1'b1, 8'h08, 1'b1, 8'h04},
    {8'h06, 1'b0, 8'h00, 1'b1, 8'h06},
    {8'h50, 1'b0, 8'h00, 1'b0, 8'h06},
    {8'h01, 1'b1, 8'h88, 1'b0, 8'h8A}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drives one frame; guard_n may change for the closing cycle. Returns at the
  // falling edge after the closing cycle, where results are due.
  task automatic frame(input logic [7:0] op, input bit has_op, input bit has_dat,
                       input logic [7:0] dat, input logic g_body, input logic g_end);
    @(negedge clk);
    guard_n = g_body;
    if (has_op) begin
      op_valid = 1'b1; op_code = op;
      @(negedge clk);
      op_valid = 1'b0;
    end
    if (has_dat) begin
      wdata_valid = 1'b1; wdata = dat;
      @(negedge clk);
      wdata_valid = 1'b0;
    end
    guard_n = g_end;
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: wel_drop = 1'b1;
      1: aai_set  = 1'b1;
      default: aai_clr = 1'b1;
    endcase
    @(negedge clk);
    wel_drop = 1'b0; aai_set = 1'b0; aai_clr = 1'b0;
  endtask

  task automatic wsr(input logic [7:0] dat, input logic g);
    frame(8'h50, 1'b1, 1'b0, 8'h00, g, g);
    frame(8'h01, 1'b1, 1'b1, dat, g, g);
  endtask

  task automatic probe(input string tag, input logic [AW-1:0] a, input logic exp);
    probe_addr = a;
    #1;
    check(tag, {31'd0, probe_locked}, {31'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after reset", {24'd0, status_byte}, 32'h0C);
    check("R1 range_any after reset", {31'd0, range_any}, 32'd1);
    check("R1 range_base after reset", {16'd0, range_base}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      frame(VEC[i][25:18], 1'b1, VEC[i][17], VEC[i][16:9], VEC[i][8], VEC[i][8]);
      check($sformatf("R6/R7/R8/R9/R10/R12 vector %0d", i),
            {24'd0, status_byte}, {24'd0, VEC[i][7:0]});
    end
    check("R12 reserved bits zero", {30'd0, status_byte[5:4]}, 32'd0);

    // R10: pin high clears lock
    wsr(8'h00, 1'b1);
    check("R10 lock cleared with pin high", {24'd0, status_byte}, 32'h02);

    // R11 range decode
    wsr(8'h04, 1'b1);
    check("R11 base for 01", {16'd0, range_base}, 32'hC000);
    probe("R11 probe BFFF", 16'hBFFF, 1'b0);
    probe("R11 probe C000", 16'hC000, 1'b1);
    wsr(8'h08, 1'b1);
    check("R11 base for 10", {16'd0, range_base}, 32'h8000);
    probe("R11 probe 7FFF", 16'h7FFF, 1'b0);
    probe("R11 probe 8000", 16'h8000, 1'b1);
    wsr(8'h00, 1'b1);
    check("R11 none for 00", {31'd0, range_any}, 32'd0);
    probe("R11 probe FFFF none", 16'hFFFF, 1'b0);

    // R2 empty frame, R4 drop
    frame(8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    check("R2 empty frame no change", {24'd0, status_byte}, 32'h02);
    pulse(0);
    check("R4 wel_drop clears latch", {24'd0, status_byte}, 32'h00);

    // R5 busy and auto-increment flag
    @(negedge clk); busy_in = 1'b1;
    @(negedge clk);
    check("R5 busy follows", {24'd0, status_byte}, 32'h01);
    busy_in = 1'b0;
    @(negedge clk);
    check("R5 busy released", {24'd0, status_byte}, 32'h00);
    pulse(1);
    check("R5 aai_set", {24'd0, status_byte}, 32'h40);
    pulse(2);
    check("R5 aai_clr", {24'd0, status_byte}, 32'h00);
    pulse(1);
    frame(8'h06, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1);
    check("R2 wren with aai", {24'd0, status_byte}, 32'h42);
    frame(8'h04, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1);
    check("R3 wrdi clears latch and aai", {24'd0, status_byte}, 32'h00);

    // R13 pin sampled at frame close
    wsr(8'h80, 1'b0);
    check("R9 lock set pin low", {24'd0, status_byte}, 32'h80);
    frame(8'h50, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    frame(8'h01, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1);
    check("R13 pin raised at close accepts", {24'd0, status_byte}, 32'h00);
    wsr(8'h80, 1'b1);
    frame(8'h50, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1);
    frame(8'h01, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0);
    check("R13 pin dropped at close refuses", {24'd0, status_byte}, 32'h80);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule